// File: doc/BRIEF.md
# Miss Holding Entry

This block is one entry of a non-blocking cache's miss tracking structure. When a lookup misses, the entry is opened for the block address. Every later request to the same block is queued on it as a target, so only one request for the block goes downstream. Each target records its origin (processor, snoop or prefetcher) and a global order number. It also records whether it needs write permission, whether it is an upgrade or a store-conditional, and whether its fill should allocate in the cache.

There are two target queues. Targets land on the primary queue unless the outstanding request will not bring back a writable line. A target that needs write permission while the entry is already in service without a pending-modified grant is parked on a deferred queue instead. The deferred queue is later promoted, as a whole, into the emptied primary queue. While the request is outstanding, snooped invalidates and reads are latched as post-invalidate and post-downgrade status. When the response arrives, the entry sorts its primary targets: those the response can serve move to the head, in order, and are marked ready for popping. The rest stay queued behind them.

Top module: `miss_hold_entry`

## Requirements
- R1: After reset, and one cycle after `dealloc_i`, the entry is invalid, both queues are empty, and every summary and status flag reads 0. `alloc_i` makes `valid_o` 1 and `addr_o` the given address on the next cycle, with empty queues and no flags set.
- R2: An accepted target goes to the deferred queue only if it needs write permission while the entry is in service and pending-modified is 0. Otherwise it goes to the primary queue. `tgt_count_o` is the sum of both queue occupancies and rises by one on the cycle after an accepted add.
- R3: Each add to the primary queue ORs the target's needs-writable, upgrade and allocate-on-fill bits into `needs_wr_o`, `has_upg_o` and `alloc_fill_o`. Pops do not clear them. Allocate and deallocate clear all three together.
- R4: A queue holding DEPTH targets is full (`prim_full_o`, `def_full_o`). An add aimed at a full queue raises `tgt_stall_o` in the same cycle and leaves the entry unchanged.
- R5: `svc_mark_i` puts the entry in service and captures `svc_pend_mod_i`. `pend_mod_o`, `post_inv_o` and `post_dgr_o` read 0 whenever `in_service_o` is 0.
- R6: While in service, `snp_inv_i` sets `post_inv_o` and `snp_read_i` sets `post_dgr_o` on the next cycle. Snoops seen while not in service have no effect.
- R7: `stat_rd_i` while not in service raises `stat_err_o` in the same cycle. While in service, `stat_err_o` stays 0.
- R8: A response of type 0 (full fill) marks every primary target ready. `head_ready_o` stays 1 until that many pops have been made.
- R9: A response of type 1 (fill carrying an unexpected invalidate) makes ready only the first target of origin 0 (processor) and every target of origin 1 (snoop). These targets move to the head in their original order. Every other target, including origin 2 (prefetcher), keeps its relative order behind them and is not ready.
- R10: A response of type 2 (line lost) makes every primary upgrade target a read-exclusive target: upgrade bit 0, needs-writable kept 1. It marks every store-conditional target as failed (`head_sc_fail_o`). It makes no target ready. Type 3 has no effect.
- R11: `pop_i` removes the primary head; targets leave in queue order. A pop on an empty primary queue has no effect.
- R12: `promote_i` acts only when the primary queue is empty and the deferred queue is not. It then moves all deferred targets, in order, to the primary queue and recomputes the three summary flags from the moved targets alone.
- R13: Only one operation per cycle acts, in this priority: deallocate, allocate, response of type 0 to 2, promotion that acts, pop on a non-empty queue, add. An add that loses to any of them raises `tgt_stall_o` and is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alloc_i | input | 1 | Open the entry for a block |
| alloc_addr_i | input | ADDR_W | Block address to record |
| dealloc_i | input | 1 | Free the entry |
| tgt_add_i | input | 1 | Add a target |
| tgt_origin_i | input | 2 | Origin: 0 processor, 1 snoop, 2 prefetcher |
| tgt_order_i | input | ORDER_W | Global order number |
| tgt_needs_wr_i | input | 1 | Target needs write permission |
| tgt_upgrade_i | input | 1 | Target is an upgrade |
| tgt_sc_i | input | 1 | Target is a store-conditional |
| tgt_alloc_i | input | 1 | Fill for this target allocates |
| tgt_stall_o | output | 1 | Add refused this cycle |
| svc_mark_i | input | 1 | Request issued downstream |
| svc_pend_mod_i | input | 1 | Fill will arrive owned and writable |
| snp_inv_i | input | 1 | Snooped invalidate |
| snp_read_i | input | 1 | Snooped read |
| rsp_valid_i | input | 1 | Response strobe |
| rsp_type_i | input | 2 | Response type code |
| pop_i | input | 1 | Remove primary head |
| promote_i | input | 1 | Promote deferred queue |
| stat_rd_i | input | 1 | Status read strobe |
| stat_err_o | output | 1 | Status read while not in service |
| valid_o | output | 1 | Entry allocated |
| addr_o | output | ADDR_W | Recorded block address |
| in_service_o | output | 1 | Request outstanding |
| pend_mod_o | output | 1 | Pending-modified status |
| post_inv_o | output | 1 | Invalidate snooped during miss |
| post_dgr_o | output | 1 | Read snooped during miss |
| needs_wr_o | output | 1 | Primary summary: needs writable |
| has_upg_o | output | 1 | Primary summary: has upgrade |
| alloc_fill_o | output | 1 | Primary summary: allocate on fill |
| tgt_count_o | output | CNT_W+1 | Targets held in both queues |
| prim_full_o | output | 1 | Primary queue full |
| def_full_o | output | 1 | Deferred queue full |
| head_valid_o | output | 1 | Primary queue not empty |
| head_ready_o | output | 1 | Head target is serviceable |
| head_origin_o | output | 2 | Head origin |
| head_order_o | output | ORDER_W | Head order number |
| head_needs_wr_o | output | 1 | Head needs writable |
| head_upgrade_o | output | 1 | Head is an upgrade |
| head_sc_o | output | 1 | Head is a store-conditional |
| head_sc_fail_o | output | 1 | Head store-conditional failed |
| head_alloc_o | output | 1 | Head allocates on fill |

## Verification
Every state change goes through a single register stage, so queue contents, counts, flags and head fields are due on the first clock edge after the strobe. The bench drives strobes just after a falling edge and reads these results at the next falling edge. Two outputs are combinational: the stall on a refused add and the error on a status read outside service. These are checked in the same cycle, a short delay after the inputs settle and before the edge. Orderings after a response are checked by popping one target per cycle and comparing each new head's order number with the expected sequence.

// File: rtl/mhe_pkg.sv
package mhe_pkg;

    parameter int ORDER_W = 16;

    typedef enum logic [1:0] {
        ORG_CPU   = 2'd0,
        ORG_SNOOP = 2'd1,
        ORG_PREF  = 2'd2
    } origin_e;

    typedef enum logic [1:0] {
        RSP_FILL      = 2'd0,
        RSP_FILL_INV  = 2'd1,
        RSP_LINE_GONE = 2'd2,
        RSP_NONE      = 2'd3
    } rsp_e;

    typedef struct packed {
        origin_e              origin;
        logic [ORDER_W-1:0]   order;
        logic                 needs_wr;
        logic                 upgrade;
        logic                 sc;
        logic                 sc_fail;
        logic                 alloc;
    } tgt_t;

    typedef struct packed {
        logic needs_wr;
        logic upgrade;
        logic alloc;
    } sum_t;

endpackage

// File: rtl/mhe_route.sv
// Chooses the destination queue for a new target and decides acceptance.
module mhe_route #(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             add,
    input  logic             needs_wr,
    input  logic             in_svc,
    input  logic             pend_mod,
    input  logic             busy,
    input  logic [CNT_W-1:0] pcnt,
    input  logic [CNT_W-1:0] dcnt,
    output logic             to_def,
    output logic             prim_full,
    output logic             def_full,
    output logic             accept,
    output logic             stall
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic dest_full;

    always_comb begin
        prim_full = (pcnt == FULL_CNT);
        def_full  = (dcnt == FULL_CNT);
        to_def    = needs_wr && in_svc && !pend_mod;
        dest_full = to_def ? def_full : prim_full;
        stall     = add && (busy || dest_full);
        accept    = add && !stall;
    end
endmodule

// File: rtl/mhe_summary.sv
// OR-reduces the summary bits over the first cnt targets of a queue.
module mhe_summary #(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  mhe_pkg::tgt_t [DEPTH-1:0] list,
    input  logic [CNT_W-1:0]          cnt,
    output mhe_pkg::sum_t             sum
);
    always_comb begin
        sum = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < cnt) begin
                sum.needs_wr = sum.needs_wr | list[i].needs_wr;
                sum.upgrade  = sum.upgrade  | list[i].upgrade;
                sum.alloc    = sum.alloc    | list[i].alloc;
            end
        end
    end
endmodule

// File: rtl/mhe_partition.sv
// Stable partition of the primary queue for an invalidating fill:
// first processor target and all snoop targets move to the front.
module mhe_partition #(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  mhe_pkg::tgt_t [DEPTH-1:0] list_in,
    input  logic [CNT_W-1:0]          cnt,
    output mhe_pkg::tgt_t [DEPTH-1:0] list_out,
    output logic [CNT_W-1:0]          nsel
);
    import mhe_pkg::*;

    logic [DEPTH-1:0] sel;

    always_comb begin
        logic seen_cpu;
        seen_cpu = 1'b0;
        sel      = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < cnt) begin
                if (list_in[i].origin == ORG_SNOOP) begin
                    sel[i] = 1'b1;
                end else if (list_in[i].origin == ORG_CPU && !seen_cpu) begin
                    sel[i]   = 1'b1;
                    seen_cpu = 1'b1;
                end
            end
        end
    end

    always_comb begin
        int k;
        list_out = list_in;
        k        = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel[i]) begin
                list_out[k] = list_in[i];
                k = k + 1;
            end
        end
        nsel = CNT_W'(k);
        for (int i = 0; i < DEPTH; i++) begin
            if ((CNT_W'(i) < cnt) && !sel[i]) begin
                list_out[k] = list_in[i];
                k = k + 1;
            end
        end
    end
endmodule

// File: rtl/miss_hold_entry.sv
module miss_hold_entry #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_i,
    input  logic [ADDR_W-1:0]           alloc_addr_i,
    input  logic                        dealloc_i,
    input  logic                        tgt_add_i,
    input  logic [1:0]                  tgt_origin_i,
    input  logic [mhe_pkg::ORDER_W-1:0] tgt_order_i,
    input  logic                        tgt_needs_wr_i,
    input  logic                        tgt_upgrade_i,
    input  logic                        tgt_sc_i,
    input  logic                        tgt_alloc_i,
    output logic                        tgt_stall_o,
    input  logic                        svc_mark_i,
    input  logic                        svc_pend_mod_i,
    input  logic                        snp_inv_i,
    input  logic                        snp_read_i,
    input  logic                        rsp_valid_i,
    input  logic [1:0]                  rsp_type_i,
    input  logic                        pop_i,
    input  logic                        promote_i,
    input  logic                        stat_rd_i,
    output logic                        stat_err_o,
    output logic                        valid_o,
    output logic [ADDR_W-1:0]           addr_o,
    output logic                        in_service_o,
    output logic                        pend_mod_o,
    output logic                        post_inv_o,
    output logic                        post_dgr_o,
    output logic                        needs_wr_o,
    output logic                        has_upg_o,
    output logic                        alloc_fill_o,
    output logic [CNT_W:0]              tgt_count_o,
    output logic                        prim_full_o,
    output logic                        def_full_o,
    output logic                        head_valid_o,
    output logic                        head_ready_o,
    output logic [1:0]                  head_origin_o,
    output logic [mhe_pkg::ORDER_W-1:0] head_order_o,
    output logic                        head_needs_wr_o,
    output logic                        head_upgrade_o,
    output logic                        head_sc_o,
    output logic                        head_sc_fail_o,
    output logic                        head_alloc_o
);
    import mhe_pkg::*;

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic                   valid;
        logic [ADDR_W-1:0]      addr;
        logic                   in_svc;
        logic                   pend_mod;
        logic                   post_inv;
        logic                   post_dgr;
        sum_t                   sum;
        tgt_t [DEPTH-1:0]       prim;
        tgt_t [DEPTH-1:0]       defr;
        logic [CNT_W-1:0]       pcnt;
        logic [CNT_W-1:0]       dcnt;
        logic [CNT_W-1:0]       rdy;
    } state_t;

    state_t st_d, st_q;

    tgt_t             new_tgt;
    tgt_t [DEPTH-1:0] part_list;
    logic [CNT_W-1:0] part_nsel;
    sum_t             def_sum;
    logic             to_def, prim_full, def_full, accept, stall;
    logic             rsp_act, promo_act, pop_act, busy;

    always_comb begin
        new_tgt          = '0;
        new_tgt.origin   = origin_e'(tgt_origin_i);
        new_tgt.order    = tgt_order_i;
        new_tgt.needs_wr = tgt_needs_wr_i;
        new_tgt.upgrade  = tgt_upgrade_i;
        new_tgt.sc       = tgt_sc_i;
        new_tgt.alloc    = tgt_alloc_i;
    end

    always_comb begin
        rsp_act   = rsp_valid_i && (rsp_type_i != RSP_NONE);
        promo_act = promote_i && (st_q.pcnt == '0) && (st_q.dcnt != '0);
        pop_act   = pop_i && (st_q.pcnt != '0);
        busy      = dealloc_i || alloc_i || rsp_act || promo_act || pop_act;
    end

    mhe_route #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_route (
        .add       (tgt_add_i),
        .needs_wr  (tgt_needs_wr_i),
        .in_svc    (st_q.in_svc),
        .pend_mod  (st_q.pend_mod),
        .busy      (busy),
        .pcnt      (st_q.pcnt),
        .dcnt      (st_q.dcnt),
        .to_def    (to_def),
        .prim_full (prim_full),
        .def_full  (def_full),
        .accept    (accept),
        .stall     (stall)
    );

    mhe_partition #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_part (
        .list_in  (st_q.prim),
        .cnt      (st_q.pcnt),
        .list_out (part_list),
        .nsel     (part_nsel)
    );

    mhe_summary #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dsum (
        .list (st_q.defr),
        .cnt  (st_q.dcnt),
        .sum  (def_sum)
    );

    always_comb begin
        st_d = st_q;
        if (dealloc_i) begin
            st_d = '0;
        end else if (alloc_i) begin
            st_d       = '0;
            st_d.valid = 1'b1;
            st_d.addr  = alloc_addr_i;
        end else begin
            // service status and snoop latching
            if (svc_mark_i) begin
                st_d.in_svc   = 1'b1;
                st_d.pend_mod = svc_pend_mod_i;
                st_d.post_inv = 1'b0;
                st_d.post_dgr = 1'b0;
            end else if (st_q.in_svc) begin
                if (snp_inv_i)  st_d.post_inv = 1'b1;
                if (snp_read_i) st_d.post_dgr = 1'b1;
            end
            // queue operation, one per cycle
            if (rsp_act) begin
                case (rsp_e'(rsp_type_i))
                    RSP_FILL: begin
                        st_d.rdy = st_q.pcnt;
                    end
                    RSP_FILL_INV: begin
                        st_d.prim = part_list;
                        st_d.rdy  = part_nsel;
                    end
                    default: begin
                        for (int i = 0; i < DEPTH; i++) begin
                            if (CNT_W'(i) < st_q.pcnt) begin
                                if (st_q.prim[i].upgrade) begin
                                    st_d.prim[i].upgrade  = 1'b0;
                                    st_d.prim[i].needs_wr = 1'b1;
                                end
                                if (st_q.prim[i].sc) begin
                                    st_d.prim[i].sc_fail = 1'b1;
                                end
                            end
                        end
                    end
                endcase
            end else if (promo_act) begin
                st_d.prim = st_q.defr;
                st_d.pcnt = st_q.dcnt;
                st_d.defr = '0;
                st_d.dcnt = '0;
                st_d.sum  = def_sum;
                st_d.rdy  = '0;
            end else if (pop_act) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    st_d.prim[i] = st_q.prim[i+1];
                end
                st_d.prim[DEPTH-1] = '0;
                st_d.pcnt = st_q.pcnt - 1'b1;
                if (st_q.rdy != '0) st_d.rdy = st_q.rdy - 1'b1;
            end else if (accept) begin
                if (to_def) begin
                    st_d.defr[st_q.dcnt[IDX_W-1:0]] = new_tgt;
                    st_d.dcnt = st_q.dcnt + 1'b1;
                end else begin
                    st_d.prim[st_q.pcnt[IDX_W-1:0]] = new_tgt;
                    st_d.pcnt         = st_q.pcnt + 1'b1;
                    st_d.sum.needs_wr = st_q.sum.needs_wr | tgt_needs_wr_i;
                    st_d.sum.upgrade  = st_q.sum.upgrade  | tgt_upgrade_i;
                    st_d.sum.alloc    = st_q.sum.alloc    | tgt_alloc_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        tgt_stall_o     = stall;
        stat_err_o      = stat_rd_i && !st_q.in_svc;
        valid_o         = st_q.valid;
        addr_o          = st_q.addr;
        in_service_o    = st_q.in_svc;
        pend_mod_o      = st_q.pend_mod & st_q.in_svc;
        post_inv_o      = st_q.post_inv & st_q.in_svc;
        post_dgr_o      = st_q.post_dgr & st_q.in_svc;
        needs_wr_o      = st_q.sum.needs_wr;
        has_upg_o       = st_q.sum.upgrade;
        alloc_fill_o    = st_q.sum.alloc;
        tgt_count_o     = {1'b0, st_q.pcnt} + {1'b0, st_q.dcnt};
        prim_full_o     = prim_full;
        def_full_o      = def_full;
        head_valid_o    = (st_q.pcnt != '0);
        head_ready_o    = (st_q.rdy != '0);
        head_origin_o   = st_q.prim[0].origin;
        head_order_o    = st_q.prim[0].order;
        head_needs_wr_o = st_q.prim[0].needs_wr;
        head_upgrade_o  = st_q.prim[0].upgrade;
        head_sc_o       = st_q.prim[0].sc;
        head_sc_fail_o  = st_q.prim[0].sc_fail;
        head_alloc_o    = st_q.prim[0].alloc;
    end
endmodule

// File: rtl/mhe_checker.sv
module mhe_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_i,
    input logic             dealloc_i,
    input logic             tgt_add_i,
    input logic             tgt_stall_o,
    input logic             rsp_valid_i,
    input logic             promote_i,
    input logic             pop_i,
    input logic             svc_mark_i,
    input logic             snp_inv_i,
    input logic             stat_rd_i,
    input logic             stat_err_o,
    input logic             valid_o,
    input logic             in_service_o,
    input logic             pend_mod_o,
    input logic             post_inv_o,
    input logic             post_dgr_o,
    input logic             needs_wr_o,
    input logic             head_valid_o,
    input logic             head_ready_o,
    input logic [CNT_W:0]   tgt_count_o
);
    a_r1_dealloc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        dealloc_i |=> (!valid_o && tgt_count_o == '0 && !in_service_o && !needs_wr_o));

    a_r2_add_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_add_i && !tgt_stall_o) |=> (tgt_count_o == $past(tgt_count_o) + 1'b1));

    a_r4_stall_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_stall_o && !dealloc_i && !alloc_i && !rsp_valid_i && !promote_i && !pop_i)
        |=> $stable(tgt_count_o));

    a_r5_status_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !in_service_o |-> (!pend_mod_o && !post_inv_o && !post_dgr_o));

    a_r6_post_inv_set: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service_o && snp_inv_i && !dealloc_i && !alloc_i && !svc_mark_i) |=> post_inv_o);

    a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !in_service_o) |-> stat_err_o);

    a_r8_ready_has_head: assert property (@(posedge clk) disable iff (!rst_n)
        head_ready_o |-> head_valid_o);
endmodule

bind miss_hold_entry mhe_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_i      (alloc_i),
    .dealloc_i    (dealloc_i),
    .tgt_add_i    (tgt_add_i),
    .tgt_stall_o  (tgt_stall_o),
    .rsp_valid_i  (rsp_valid_i),
    .promote_i    (promote_i),
    .pop_i        (pop_i),
    .svc_mark_i   (svc_mark_i),
    .snp_inv_i    (snp_inv_i),
    .stat_rd_i    (stat_rd_i),
    .stat_err_o   (stat_err_o),
    .valid_o      (valid_o),
    .in_service_o (in_service_o),
    .pend_mod_o   (pend_mod_o),
    .post_inv_o   (post_inv_o),
    .post_dgr_o   (post_dgr_o),
    .needs_wr_o   (needs_wr_o),
    .head_valid_o (head_valid_o),
    .head_ready_o (head_ready_o),
    .tgt_count_o  (tgt_count_o)
);

// File: tb/miss_hold_entry_tb.sv
module miss_hold_entry_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int DEPTH  = 8;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int OW     = mhe_pkg::ORDER_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_i, dealloc_i, tgt_add_i, tgt_needs_wr_i, tgt_upgrade_i, tgt_sc_i, tgt_alloc_i;
    logic [ADDR_W-1:0] alloc_addr_i;
    logic [1:0] tgt_origin_i, rsp_type_i;
    logic [OW-1:0] tgt_order_i;
    logic svc_mark_i, svc_pend_mod_i, snp_inv_i, snp_read_i, rsp_valid_i, pop_i, promote_i, stat_rd_i;
    logic tgt_stall_o, stat_err_o, valid_o, in_service_o, pend_mod_o, post_inv_o, post_dgr_o;
    logic needs_wr_o, has_upg_o, alloc_fill_o, prim_full_o, def_full_o, head_valid_o, head_ready_o;
    logic [ADDR_W-1:0] addr_o;
    logic [CNT_W:0] tgt_count_o;
    logic [1:0] head_origin_o;
    logic [OW-1:0] head_order_o;
    logic head_needs_wr_o, head_upgrade_o, head_sc_o, head_sc_fail_o, head_alloc_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    miss_hold_entry #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dut (.*);

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        alloc_i = 0; alloc_addr_i = '0; dealloc_i = 0; tgt_add_i = 0;
        tgt_origin_i = 0; tgt_order_i = '0; tgt_needs_wr_i = 0; tgt_upgrade_i = 0;
        tgt_sc_i = 0; tgt_alloc_i = 0; svc_mark_i = 0; svc_pend_mod_i = 0;
        snp_inv_i = 0; snp_read_i = 0; rsp_valid_i = 0; rsp_type_i = 0;
        pop_i = 0; promote_i = 0; stat_rd_i = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic set_add(input int org, input int ord, input bit nw, input bit up,
                           input bit sc, input bit al);
        tgt_add_i = 1; tgt_origin_i = 2'(org); tgt_order_i = OW'(ord);
        tgt_needs_wr_i = nw; tgt_upgrade_i = up; tgt_sc_i = sc; tgt_alloc_i = al;
    endtask

    task automatic do_add(input int org, input int ord, input bit nw, input bit up,
                          input bit sc, input bit al);
        set_add(org, ord, nw, up, sc, al);
        step();
    endtask

    task automatic do_alloc(input logic [ADDR_W-1:0] a);
        alloc_i = 1; alloc_addr_i = a; step();
    endtask

    task automatic do_dealloc();
        dealloc_i = 1; step();
    endtask

    task automatic do_pop();
        pop_i = 1; step();
    endtask

    task automatic do_rsp(input int t);
        rsp_valid_i = 1; rsp_type_i = 2'(t); step();
    endtask

    task automatic t_reset();
        chk("R1 reset valid", valid_o, 0);
        chk("R1 reset count", tgt_count_o, 0);
        chk("R1 reset in_service", in_service_o, 0);
        chk("R1 reset flags", {needs_wr_o, has_upg_o, alloc_fill_o}, 0);
        chk("R1 reset head", head_valid_o, 0);
    endtask

    task automatic t_main_flow();
        do_alloc(32'h1234_5640);
        chk("R1 alloc valid", valid_o, 1);
        chk("R1 alloc addr", addr_o, 32'h1234_5640);
        do_add(0, 1, 1, 0, 0, 1);
        chk("R2 primary add count", tgt_count_o, 1);
        chk("R3 needs_wr flag", needs_wr_o, 1);
        chk("R3 alloc flag", alloc_fill_o, 1);
        chk("R3 upgrade flag", has_upg_o, 0);
        svc_mark_i = 1; svc_pend_mod_i = 0; step();
        chk("R5 in service", in_service_o, 1);
        chk("R5 pend_mod captured", pend_mod_o, 0);
        do_add(0, 2, 1, 0, 0, 0);
        chk("R2 deferred add count", tgt_count_o, 2);
        chk("R2 deferred head kept", head_order_o, 1);
        do_add(2, 3, 0, 0, 0, 0);
        chk("R2 count sum", tgt_count_o, 3);
        snp_read_i = 1; step();
        chk("R6 post_dgr set", post_dgr_o, 1);
        chk("R6 post_inv clear", post_inv_o, 0);
        stat_rd_i = 1; #1;
        chk("R7 no err in service", stat_err_o, 0);
        stat_rd_i = 0;
        do_rsp(0);
        chk("R8 ready after fill", head_ready_o, 1);
        chk("R11 head first", head_order_o, 1);
        do_pop();
        chk("R11 second head", head_order_o, 3);
        chk("R8 still ready", head_ready_o, 1);
        do_pop();
        chk("R11 primary empty", head_valid_o, 0);
        chk("R8 ready drained", head_ready_o, 0);
        chk("R2 deferred remains", tgt_count_o, 1);
        chk("R3 pop keeps alloc flag", alloc_fill_o, 1);
        promote_i = 1; step();
        chk("R12 promoted head", head_order_o, 2);
        chk("R12 promoted head nw", head_needs_wr_o, 1);
        chk("R12 alloc flag recomputed", alloc_fill_o, 0);
        chk("R12 needs_wr recomputed", needs_wr_o, 1);
        chk("R12 count", tgt_count_o, 1);
        do_dealloc();
        chk("R1 dealloc valid", valid_o, 0);
        chk("R1 dealloc count", tgt_count_o, 0);
        chk("R1 dealloc flags", {in_service_o, post_dgr_o, needs_wr_o}, 0);
    endtask

    task automatic t_full();
        do_alloc(32'h40);
        for (int i = 0; i < DEPTH; i++) do_add(2, 40 + i, 0, 0, 0, 0);
        chk("R4 primary full", prim_full_o, 1);
        set_add(2, 99, 0, 0, 0, 0); #1;
        chk("R4 stall when full", tgt_stall_o, 1);
        step();
        chk("R4 count unchanged", tgt_count_o, DEPTH);
        promote_i = 1; step();
        chk("R12 promote ignored when primary busy", head_order_o, 40);
        do_dealloc();
    endtask

    task automatic t_inval();
        do_alloc(32'h80);
        do_add(2, 10, 0, 0, 0, 0);
        do_add(0, 11, 0, 0, 0, 0);
        do_add(1, 12, 0, 0, 0, 0);
        do_add(0, 13, 0, 0, 0, 0);
        do_add(1, 14, 0, 0, 0, 0);
        svc_mark_i = 1; svc_pend_mod_i = 1; step();
        chk("R5 pend_mod set", pend_mod_o, 1);
        do_add(0, 15, 1, 0, 0, 0);
        do_rsp(1);
        chk("R9 head first cpu", head_order_o, 11);
        chk("R9 ready", head_ready_o, 1);
        do_pop();
        chk("R9 snoop next", head_order_o, 12);
        do_pop();
        chk("R9 second snoop", head_order_o, 14);
        chk("R9 snoop ready", head_ready_o, 1);
        do_pop();
        chk("R9 prefetch stays", head_order_o, 10);
        chk("R9 not ready", head_ready_o, 0);
        do_pop();
        chk("R9 second cpu stays", head_order_o, 13);
        do_pop();
        chk("R2 pend_mod routes primary", head_order_o, 15);
        do_dealloc();
    endtask

    task automatic t_rewrite();
        do_alloc(32'hc0);
        do_add(0, 20, 1, 1, 0, 0);
        do_add(0, 21, 1, 0, 1, 0);
        chk("R3 upgrade flag", has_upg_o, 1);
        do_rsp(2);
        chk("R10 upgrade cleared", head_upgrade_o, 0);
        chk("R10 read exclusive", head_needs_wr_o, 1);
        chk("R10 no ready", head_ready_o, 0);
        do_pop();
        chk("R10 sc failed", {head_sc_o, head_sc_fail_o}, 2'b11);
        do_rsp(3);
        chk("R10 type3 no effect", {head_ready_o, tgt_count_o}, {1'b0, 5'(1)});
        do_dealloc();
    endtask

    task automatic t_idle_status();
        do_alloc(32'h100);
        snp_inv_i = 1; step();
        chk("R6 snoop ignored out of service", post_inv_o, 0);
        stat_rd_i = 1; #1;
        chk("R7 err out of service", stat_err_o, 1);
        step();
        svc_mark_i = 1; step();
        chk("R6 snoop did not stick", post_inv_o, 0);
        snp_inv_i = 1; step();
        chk("R6 post_inv set", post_inv_o, 1);
        do_dealloc();
    endtask

    task automatic t_priority();
        do_alloc(32'h140);
        do_add(0, 30, 0, 0, 0, 0);
        do_add(0, 31, 0, 0, 0, 0);
        pop_i = 1; set_add(0, 32, 0, 0, 0, 0); #1;
        chk("R13 add loses to pop", tgt_stall_o, 1);
        step();
        chk("R13 pop took effect", head_order_o, 31);
        chk("R13 add dropped", tgt_count_o, 1);
        dealloc_i = 1; alloc_i = 1; alloc_addr_i = 32'h180; step();
        chk("R13 dealloc over alloc", valid_o, 0);
    endtask

    initial begin
        idle();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_main_flow();
        t_full();
        t_inval();
        t_rewrite();
        t_idle_status();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule